// File: doc/BRIEF.md
# Wide Load/Store Beat Sequencer

This block carries out 64-bit (doubleword) and 128-bit (quadword) loads and stores over a memory port that is only 32 bits wide. It accepts a memory instruction word together with the value of its base register and the store data. It decodes the operation and computes the effective address. It then checks alignment. A legal access becomes a run of consecutive 32-bit beats on a valid/ready memory port. A misaligned access raises an address-error fault instead. Load data lands lane by lane in a 128-bit register file. The block also keeps a 32-bit architectural view of each register, and that view is updated from the lowest lane.

A single beat counter serves both widths. It is cleared when an access is dispatched. Each beat targets `ea + 4*beat`, and the sequence ends after beat 1 for doublewords or after beat 3 for quadwords. A doubleword load therefore touches only the two low lanes of its target register and leaves the upper 64 bits as they were. Stores take their beat data from the matching 32-bit lane of the supplied 128-bit value, starting with the lowest lane.

The controller has four states:
- `ST_IDLE`: ready for a request.
- `ST_ISSUE`: latches the beat address and the beat data.
- `ST_WAIT`: holds the memory request until it is acknowledged.
- `ST_FAULT`: reports a fault for one cycle.

The transitions are:
- accept: `ST_IDLE` to `ST_ISSUE`, for a legal aligned request.
- reject: `ST_IDLE` to `ST_FAULT`, for a legal but misaligned request.
- present: `ST_ISSUE` to `ST_WAIT`.
- next-beat: `ST_WAIT` to `ST_ISSUE`, on a handshake that is not the final beat.
- finish: `ST_WAIT` to `ST_IDLE`, on the handshake of the final beat.
- report: `ST_FAULT` to `ST_IDLE`.

Top module: `wide_ls_seq`

## Requirements
- R1: The instruction's bits 31:26 select the operation: 0x37 is a doubleword load, 0x3F a doubleword store, 0x1E a quadword load and 0x1F a quadword store. Bits 20:16 name the target register, and bits 15:0 are a signed offset added to `req_base` to form the effective address. The word 0xDFBF0000 is therefore a doubleword load into register 31. Any other opcode is ignored: it produces no beat, no fault and no register change, and `busy` stays low.
- R2: A legal, aligned access issues exactly 2 beats for a doubleword or 4 for a quadword. Beat k uses byte address `ea + 4*k`, and the beats go out in ascending order of k.
- R3: On a doubleword load, beat 0 writes `mem_rdata` into bits 31:0 of the target wide register and into its 32-bit architectural view. Beat 1 writes bits 63:32. Bits 127:64 keep their previous value.
- R4: On a quadword load, beats 0 to 3 write bits 31:0, 63:32, 95:64 and 127:96 in that order. Beat 0 also writes the architectural view.
- R5: A store drives `mem_we` high. Beat k carries bits `32k+31:32k` of `req_wdata`. A store changes no register.
- R6: A doubleword access whose address has a nonzero `ea[2:0]`, or a quadword access with a nonzero `ea[3:0]`, issues no beat and changes no register. One cycle after acceptance it pulses `flt_valid`, with `flt_store` = 0 for a load and 1 for a store, and `flt_addr` = ea.
- R7: `busy` is high from the cycle after acceptance until the final beat's handshake and low in the cycle after that. `req_ready` is the inverse of `busy`, and a request presented while busy is ignored.
- R8: `mem_valid`, `mem_addr`, `mem_we` and `mem_wdata` stay unchanged until `mem_ready` is seen. The beat index advances only on a completed handshake.
- R9: After reset every register, wide and architectural, reads as zero, and `busy`, `mem_valid` and `flt_valid` are low. `rd_wide` and `rd_arch` show register `rd_idx` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle; a request is taken this cycle |
| req_insn | input | 32 | Memory instruction word |
| req_base | input | AW | Value of the base register |
| req_wdata | input | 128 | Store data, lane 0 in bits 31:0 |
| busy | output | 1 | Access in progress or fault being reported |
| mem_valid | output | 1 | Memory beat request |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | AW | Byte address of the beat |
| mem_wdata | output | 32 | Write data of the beat |
| mem_ready | input | 1 | Memory acknowledges the beat |
| mem_rdata | input | 32 | Read data of the beat |
| flt_valid | output | 1 | Address-error fault pulse |
| flt_store | output | 1 | Fault came from a store (0: load) |
| flt_addr | output | AW | Faulting effective address |
| rd_idx | input | log2(NREG) | Register view select |
| rd_wide | output | 128 | Wide register contents |
| rd_arch | output | 32 | Architectural 32-bit view |

## Verification
The riskiest coincidence is the final beat's handshake landing in the same cycle as a new request. The finish transition then competes with a request that must not be taken. The bench provokes this by raising `req_valid` for a doubleword load into register 30 exactly in the cycle where it sees `mem_ready` on the last beat. It then confirms that register 30 is untouched and that no extra beats appeared. A second coincidence is beat 0 of a load, which writes the low lane and the architectural view together. It is judged by comparing both views of the register after each load, under memory latencies of 0, 1 and 2 cycles.

// File: rtl/wls_pkg.sv
`timescale 1ns/1ps
package wls_pkg;

    localparam logic [5:0] OPC_LOAD_D  = 6'h37;
    localparam logic [5:0] OPC_STORE_D = 6'h3F;
    localparam logic [5:0] OPC_LOAD_Q  = 6'h1E;
    localparam logic [5:0] OPC_STORE_Q = 6'h1F;

    typedef enum logic [1:0] {
        MOP_LOAD_D  = 2'd0,
        MOP_STORE_D = 2'd1,
        MOP_LOAD_Q  = 2'd2,
        MOP_STORE_Q = 2'd3
    } memop_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_FAULT = 2'd3
    } seq_state_e;

endpackage

// File: rtl/wls_decode.sv
`timescale 1ns/1ps
module wls_decode
    import wls_pkg::*;
#(
    parameter int AW     = 32,
    parameter int LANE_W = 32,
    parameter int LANES  = 4
) (
    input  logic [31:0]   insn,
    input  logic [AW-1:0] base_val,
    output logic          legal,
    output memop_e        op,
    output logic          is_store,
    output logic          is_quad,
    output logic [4:0]    rt,
    output logic [AW-1:0] ea,
    output logic          misaligned
);
    localparam int DW_ALIGN_BITS = $clog2(2 * LANE_W / 8);
    localparam int QW_ALIGN_BITS = $clog2(LANES * LANE_W / 8);
    localparam logic [AW-1:0] DW_MASK = AW'((1 << DW_ALIGN_BITS) - 1);
    localparam logic [AW-1:0] QW_MASK = AW'((1 << QW_ALIGN_BITS) - 1);

    logic [5:0] opc;

    assign opc = insn[31:26];
    assign rt  = insn[20:16];
    assign ea  = base_val + {{(AW-16){insn[15]}}, insn[15:0]};

    always_comb begin
        legal = 1'b1;
        op    = MOP_LOAD_D;
        unique case (opc)
            OPC_LOAD_D:  op = MOP_LOAD_D;
            OPC_STORE_D: op = MOP_STORE_D;
            OPC_LOAD_Q:  op = MOP_LOAD_Q;
            OPC_STORE_Q: op = MOP_STORE_Q;
            default:     legal = 1'b0;
        endcase
    end

    assign is_store   = (op == MOP_STORE_D) || (op == MOP_STORE_Q);
    assign is_quad    = (op == MOP_LOAD_Q)  || (op == MOP_STORE_Q);
    assign misaligned = is_quad ? |(ea & QW_MASK) : |(ea & DW_MASK);

endmodule

// File: rtl/wls_regfile.sv
`timescale 1ns/1ps
module wls_regfile #(
    parameter int NREG   = 32,
    parameter int LANE_W = 32,
    parameter int LANES  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [$clog2(NREG)-1:0]   wr_idx,
    input  logic [$clog2(LANES)-1:0]  wr_lane,
    input  logic                      wr_arch,
    input  logic [LANE_W-1:0]         wr_data,
    input  logic [$clog2(NREG)-1:0]   rd_idx,
    output logic [LANE_W*LANES-1:0]   rd_wide,
    output logic [LANE_W-1:0]         rd_arch
);
    localparam int RIDX_W = $clog2(NREG);
    localparam int BEAT_W = $clog2(LANES);

    logic [LANE_W-1:0] lane_q [NREG][LANES];
    logic [LANE_W-1:0] arch_q [NREG];

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    lane_q[r][l] <= '0;
                end else if (wr_en && wr_idx == RIDX_W'(r) && wr_lane == BEAT_W'(l)) begin
                    lane_q[r][l] <= wr_data;
                end
            end
        end
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                arch_q[r] <= '0;
            end else if (wr_arch && wr_idx == RIDX_W'(r)) begin
                arch_q[r] <= wr_data;
            end
        end
    end

    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            rd_wide[l*LANE_W +: LANE_W] = lane_q[rd_idx][l];
        end
        rd_arch = arch_q[rd_idx];
    end

    AST_ARCH_LOW_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_arch |-> (wr_en && wr_lane == '0)); // R3

endmodule

// File: rtl/wls_seq.sv
`timescale 1ns/1ps
module wls_seq
    import wls_pkg::*;
#(
    parameter int AW     = 32,
    parameter int LANE_W = 32,
    parameter int LANES  = 4,
    parameter int RIDX_W = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic                       req_legal,
    input  logic                       req_store,
    input  logic                       req_quad,
    input  logic                       req_misaligned,
    input  logic [RIDX_W-1:0]          req_rt,
    input  logic [AW-1:0]              req_ea,
    input  logic [LANE_W*LANES-1:0]    req_wdata,
    output logic                       req_ready,
    output logic                       busy,
    output logic                       mem_valid,
    output logic                       mem_we,
    output logic [AW-1:0]              mem_addr,
    output logic [LANE_W-1:0]          mem_wdata,
    input  logic                       mem_ready,
    output logic                       rf_we,
    output logic                       rf_arch_we,
    output logic [RIDX_W-1:0]          rf_idx,
    output logic [$clog2(LANES)-1:0]   rf_lane,
    output logic                       flt_valid,
    output logic                       flt_store,
    output logic [AW-1:0]              flt_addr
);
    localparam int WIDE_W = LANE_W * LANES;
    localparam int BEAT_W = $clog2(LANES);
    localparam int SHIFT  = $clog2(LANE_W / 8);
    localparam logic [BEAT_W-1:0] DW_LAST = BEAT_W'(LANES / 2 - 1);
    localparam logic [BEAT_W-1:0] QW_LAST = BEAT_W'(LANES - 1);

    seq_state_e         state, nxt;
    logic [BEAT_W-1:0]  beat;
    logic [AW-1:0]      ea_q;
    logic [AW-1:0]      addr_q;
    logic [RIDX_W-1:0]  rt_q;
    logic               store_q;
    logic               quad_q;
    logic [WIDE_W-1:0]  wdata_q;
    logic [LANE_W-1:0]  wd_q;
    logic [LANE_W-1:0]  lane_sel;
    logic [BEAT_W-1:0]  last_beat;
    logic               at_last;
    logic               take;
    logic               hs;

    assign take      = req_valid && req_legal && (state == ST_IDLE);
    assign last_beat = quad_q ? QW_LAST : DW_LAST;
    assign at_last   = (beat == last_beat);
    assign hs        = (state == ST_WAIT) && mem_ready;

    always_comb begin
        lane_sel = '0;
        for (int k = 0; k < LANES; k++) begin
            if (beat == BEAT_W'(k)) lane_sel = wdata_q[k*LANE_W +: LANE_W];
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Next-state logic: accept, reject, present, next-beat, finish, report
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (take) nxt = req_misaligned ? ST_FAULT : ST_ISSUE;
            ST_ISSUE: nxt = ST_WAIT;
            ST_WAIT:  if (mem_ready) nxt = at_last ? ST_IDLE : ST_ISSUE;
            ST_FAULT: nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // Access context and beat datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat    <= '0;
            ea_q    <= '0;
            addr_q  <= '0;
            rt_q    <= '0;
            store_q <= 1'b0;
            quad_q  <= 1'b0;
            wdata_q <= '0;
            wd_q    <= '0;
        end else begin
            if (take) begin
                beat    <= '0;
                ea_q    <= req_ea;
                rt_q    <= req_rt;
                store_q <= req_store;
                quad_q  <= req_quad;
                wdata_q <= req_wdata;
            end
            if (state == ST_ISSUE) begin
                addr_q <= ea_q + (AW'(beat) << SHIFT);
                wd_q   <= lane_sel;
            end
            if (hs && !at_last) begin
                beat <= beat + 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        req_ready  = (state == ST_IDLE);
        busy       = (state != ST_IDLE);
        mem_valid  = (state == ST_WAIT);
        mem_we     = (state == ST_WAIT) && store_q;
        mem_addr   = addr_q;
        mem_wdata  = wd_q;
        rf_we      = hs && !store_q;
        rf_arch_we = hs && !store_q && (beat == '0);
        rf_idx     = rt_q;
        rf_lane    = beat;
        flt_valid  = (state == ST_FAULT);
        flt_store  = store_q;
        flt_addr   = ea_q;
    end

    AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R8
    AST_HOLD_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> $stable(beat)); // R8
    AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid |-> (!mem_valid && !rf_we)); // R6
    AST_BEAT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (beat <= last_beat)); // R2
    AST_IDLE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready && at_last) |=> !busy); // R7
    AST_STORE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> !mem_we); // R5

endmodule

// File: rtl/wide_ls_seq.sv
`timescale 1ns/1ps
module wide_ls_seq
    import wls_pkg::*;
#(
    parameter int AW     = 32,
    parameter int LANE_W = 32,
    parameter int LANES  = 4,
    parameter int NREG   = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [31:0]               req_insn,
    input  logic [AW-1:0]             req_base,
    input  logic [LANE_W*LANES-1:0]   req_wdata,
    output logic                      busy,
    output logic                      mem_valid,
    output logic                      mem_we,
    output logic [AW-1:0]             mem_addr,
    output logic [LANE_W-1:0]         mem_wdata,
    input  logic                      mem_ready,
    input  logic [LANE_W-1:0]         mem_rdata,
    output logic                      flt_valid,
    output logic                      flt_store,
    output logic [AW-1:0]             flt_addr,
    input  logic [$clog2(NREG)-1:0]   rd_idx,
    output logic [LANE_W*LANES-1:0]   rd_wide,
    output logic [LANE_W-1:0]         rd_arch
);
    localparam int RIDX_W = $clog2(NREG);
    localparam int BEAT_W = $clog2(LANES);

    logic              dec_legal, dec_store, dec_quad, dec_mis;
    memop_e            dec_op;
    logic [4:0]        dec_rt;
    logic [AW-1:0]     dec_ea;
    logic              rf_we, rf_arch_we;
    logic [RIDX_W-1:0] rf_idx;
    logic [BEAT_W-1:0] rf_lane;

    wls_decode #(.AW(AW), .LANE_W(LANE_W), .LANES(LANES)) u_dec (
        .insn       (req_insn),
        .base_val   (req_base),
        .legal      (dec_legal),
        .op         (dec_op),
        .is_store   (dec_store),
        .is_quad    (dec_quad),
        .rt         (dec_rt),
        .ea         (dec_ea),
        .misaligned (dec_mis)
    );

    wls_seq #(.AW(AW), .LANE_W(LANE_W), .LANES(LANES), .RIDX_W(RIDX_W)) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_legal      (dec_legal),
        .req_store      (dec_store),
        .req_quad       (dec_quad),
        .req_misaligned (dec_mis),
        .req_rt         (dec_rt[RIDX_W-1:0]),
        .req_ea         (dec_ea),
        .req_wdata      (req_wdata),
        .req_ready      (req_ready),
        .busy           (busy),
        .mem_valid      (mem_valid),
        .mem_we         (mem_we),
        .mem_addr       (mem_addr),
        .mem_wdata      (mem_wdata),
        .mem_ready      (mem_ready),
        .rf_we          (rf_we),
        .rf_arch_we     (rf_arch_we),
        .rf_idx         (rf_idx),
        .rf_lane        (rf_lane),
        .flt_valid      (flt_valid),
        .flt_store      (flt_store),
        .flt_addr       (flt_addr)
    );

    wls_regfile #(.NREG(NREG), .LANE_W(LANE_W), .LANES(LANES)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (rf_we),
        .wr_idx  (rf_idx),
        .wr_lane (rf_lane),
        .wr_arch (rf_arch_we),
        .wr_data (mem_rdata),
        .rd_idx  (rd_idx),
        .rd_wide (rd_wide),
        .rd_arch (rd_arch)
    );

    AST_IGNORE_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !dec_legal) |=> !busy); // R1
    AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_valid && !flt_valid)); // R7

endmodule

// File: tb/tb_wide_ls_seq.sv
`timescale 1ns/1ps
module tb_wide_ls_seq;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [31:0]  req_insn = '0;
    logic [31:0]  req_base = '0;
    logic [127:0] req_wdata = '0;
    logic         busy;
    logic         mem_valid, mem_we;
    logic [31:0]  mem_addr, mem_wdata;
    logic         mem_ready;
    logic [31:0]  mem_rdata;
    logic         flt_valid, flt_store;
    logic [31:0]  flt_addr;
    logic [4:0]   rd_idx = '0;
    logic [127:0] rd_wide;
    logic [31:0]  rd_arch;

    wide_ls_seq dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_insn(req_insn),
        .req_base(req_base), .req_wdata(req_wdata), .busy(busy),
        .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .flt_valid(flt_valid), .flt_store(flt_store), .flt_addr(flt_addr),
        .rd_idx(rd_idx), .rd_wide(rd_wide), .rd_arch(rd_arch)
    );

    always #2 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int lat = 0;
    int wcnt;
    int beat_n;
    logic [31:0]  mem [64];
    logic [31:0]  log_addr [1024];
    logic         log_we   [1024];
    logic [31:0]  log_wd   [1024];
    logic [127:0] exp_wide [32];
    logic [31:0]  exp_arch [32];

    function automatic logic [31:0] seed(int i);
        return 32'h3C00_0000 ^ (32'(i) * 32'h0101_0407);
    endfunction

    assign mem_ready = mem_valid && (wcnt >= lat);
    assign mem_rdata = mem[mem_addr[7:2]];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) mem[i] <= seed(i);
            wcnt   <= 0;
            beat_n <= 0;
        end else if (mem_valid) begin
            if (mem_ready) begin
                log_addr[beat_n % 1024] <= mem_addr;
                log_we[beat_n % 1024]   <= mem_we;
                log_wd[beat_n % 1024]   <= mem_wdata;
                beat_n <= beat_n + 1;
                wcnt   <= 0;
                if (mem_we) mem[mem_addr[7:2]] <= mem_wdata;
            end else begin
                wcnt <= wcnt + 1;
            end
        end
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL R7 watchdog expired actual=%0d expected<=150000", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(bit ok, string tag, logic [127:0] act, logic [127:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic check_reg(int r, string tag);
        rd_idx = 5'(r);
        #0.5;
        chk(rd_wide == exp_wide[r], {tag, " wide register"}, rd_wide, exp_wide[r]);
        chk(rd_arch == exp_arch[r], {tag, " architectural view"}, 128'(rd_arch), 128'(exp_arch[r]));
    endtask

    task automatic run_op(logic [5:0] opc, int rt, logic [31:0] base, logic [15:0] off,
                          logic [127:0] wd, int l, bit intrude);
        logic [31:0] ea;
        bit legal, st, qd, mis;
        int n, start, waitc, idx;
        string tg;
        ea    = base + {{16{off[15]}}, off};
        legal = (opc == 6'h37) || (opc == 6'h3F) || (opc == 6'h1E) || (opc == 6'h1F);
        st    = (opc == 6'h3F) || (opc == 6'h1F);
        qd    = (opc == 6'h1E) || (opc == 6'h1F);
        mis   = qd ? (ea[3:0] != 4'd0) : (ea[2:0] != 3'd0);
        n     = (!legal || mis) ? 0 : (qd ? 4 : 2);
        tg    = st ? "R5" : (qd ? "R4" : "R3");
        if (mis) tg = "R6";
        lat   = l;
        @(negedge clk);
        start     = beat_n;
        req_insn  = {opc, 5'd29, 5'(rt), off};
        req_base  = base;
        req_wdata = wd;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (!legal) begin
            repeat (3) @(negedge clk);
            chk(busy == 1'b0, "R1 illegal opcode busy", 128'(busy), 128'(0));
            chk(beat_n == start, "R1 illegal opcode beats", 128'(beat_n - start), 128'(0));
            check_reg(rt, "R1 illegal opcode");
            return;
        end
        chk(busy == 1'b1, "R7 busy after accept", 128'(busy), 128'(1));
        if (mis) begin
            chk(flt_valid && (flt_store == st) && (flt_addr == ea), "R6 fault report",
                {flt_valid, flt_store, flt_addr}, {1'b1, st, ea});
        end else begin
            chk(!flt_valid, "R6 no fault when aligned", 128'(flt_valid), 128'(0));
        end
        waitc = 0;
        while (busy && waitc < 200) begin
            req_valid = 1'b0;
            if (intrude && mem_valid && mem_ready && (beat_n - start == n - 1)) begin
                req_insn  = {6'h37, 5'd29, 5'd30, 16'h0000};
                req_base  = 32'h0;
                req_valid = 1'b1;
            end
            @(negedge clk);
            waitc++;
        end
        req_valid = 1'b0;
        chk(waitc < 200, "R7 busy released", 128'(waitc), 128'(200));
        chk(beat_n - start == n, (l > 0) ? "R8 beat count under stalls" : "R2 beat count",
            128'(beat_n - start), 128'(n));
        for (int k = 0; k < n; k++) begin
            idx = (start + k) % 1024;
            chk(log_addr[idx] == ea + 32'(4 * k), "R2 beat address",
                128'(log_addr[idx]), 128'(ea + 32'(4 * k)));
            chk(log_we[idx] == st, "R5 beat direction", 128'(log_we[idx]), 128'(st));
            if (st) begin
                chk(log_wd[idx] == wd[k*32 +: 32], "R5 store lane data",
                    128'(log_wd[idx]), 128'(wd[k*32 +: 32]));
            end
        end
        if (n > 0 && !st) begin
            for (int k = 0; k < n; k++) begin
                exp_wide[rt][k*32 +: 32] = mem[((ea >> 2) + 32'(k)) & 32'h3F];
            end
            exp_arch[rt] = mem[(ea >> 2) & 32'h3F];
        end
        check_reg(rt, tg);
        if (intrude) check_reg(30, "R7 request during final beat ignored");
    endtask

    initial begin
        for (int r = 0; r < 32; r++) begin
            exp_wide[r] = '0;
            exp_arch[r] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && req_ready && !mem_valid && !flt_valid, "R9 reset outputs",
            {busy, req_ready, mem_valid, flt_valid}, 128'b0100);
        check_reg(7, "R9 reset register");
        check_reg(31, "R9 reset register");

        // R1: 0xDFBF0000 loads register 31 from base + 0
        run_op(6'h37, 31, 32'h0000_0040, 16'h0000, '0, 0, 1'b0);
        chk({6'h37, 5'd29, 5'd31, 16'h0} == 32'hDFBF_0000, "R1 encoding layout",
            128'({6'h37, 5'd29, 5'd31, 16'h0}), 128'(32'hDFBF_0000));
        run_op(6'h23, 4, 32'h40, 16'h0, '0, 0, 1'b0);
        run_op(6'h00, 4, 32'h40, 16'h0, '0, 0, 1'b0);
        run_op(6'h3E, 4, 32'h40, 16'h0, '0, 0, 1'b0);

        // Stores (R5, R6)
        for (int i = 0; i < 16; i++) begin
            run_op(6'h3F, i * 2 + 1, 32'h0000_00C0, 16'(i * 4 + ((i == 9) ? 1 : 0)),
                   {32'hD000_0000 + 32'(i), 32'hC000_0000 + 32'(i),
                    32'hB000_0000 + 32'(i), 32'hA000_0000 + 32'(i)}, i % 3, (i % 4) == 0);
        end
        for (int i = 0; i < 16; i++) begin
            run_op(6'h1F, i * 2 + 1, 32'h0000_0000, 16'(i * 4 + ((i == 9) ? 1 : 0)),
                   {32'h4400_0000 + 32'(i), 32'h3300_0000 + 32'(i),
                    32'h2200_0000 + 32'(i), 32'h1100_0000 + 32'(i)}, (i + 1) % 3, (i % 4) == 0);
        end
        // Quadword loads (R4, R6)
        for (int i = 0; i < 16; i++) begin
            run_op(6'h1E, (i & ~3) * 2 + 1, 32'h0000_0080, 16'(i * 4 + ((i == 6) ? 3 : 0)),
                   '0, i % 3, (i % 4) == 0);
        end
        // Doubleword loads over filled registers (R3, R6)
        for (int i = 0; i < 16; i++) begin
            run_op(6'h37, (i & ~3) * 2 + 1, 32'h0000_0040, 16'(i * 4 + ((i == 10) ? 2 : 0)),
                   '0, (i + 2) % 3, (i % 4) == 2);
        end
        // Negative offset, then a quadword over a doubleword
        run_op(6'h37, 12, 32'h0000_00A0, 16'hFFF8, '0, 1, 1'b0);
        run_op(6'h1E, 12, 32'h0000_0020, 16'h0000, '0, 2, 1'b0);
        run_op(6'h37, 12, 32'h0000_0008, 16'h0000, '0, 0, 1'b1);

        summary();
        $finish;
    end

endmodule